// File: doc/BRIEF.md
# Incremental Quadrature Encoder Emulator

This block turns an absolute shaft angle into the signals of an incremental rotary encoder. A tracking converter upstream produces a 12-bit angle that moves by at most one LSB per position update. This block samples that angle whenever its update enable is high. From the sampled value it drives two quadrature channels, a direction line and a once-per-turn marker. The outputs run freely, and nothing has to strobe them. A motor controller that expects a 1024-line encoder can therefore take them directly.

Each angle LSB maps to exactly one quadrature state, so four updates make one full A cycle and one turn makes 1024 cycles. At the nominal update rate of 4.096 MHz, the channels switch at up to 1.024 MHz. The direction line is driven directly by comparing each newly sampled angle with the previous one modulo one turn. The receiver therefore never needs to decode A and B to learn the sense of rotation.

Top module: `quad_encoder_emu`

## Requirements
- R1: While reset is held, on the first clock edge the sampled angle becomes 0x000, which gives enc_a=0, enc_b=0 and enc_nm=1, and enc_dir becomes 1.
- R2: Outputs follow the two low bits of the sampled angle: 00 gives A=0,B=0; 01 gives A=1,B=0; 10 gives A=1,B=1; 11 gives A=0,B=1.
- R3: While the angle increases one LSB at a time, A changes one update before B (A leads B); while it decreases, B leads A.
- R4: One full turn of 4096 single-LSB increasing steps produces exactly 1024 rising edges of enc_a and exactly one marker pulse.
- R5: The sampled angle and all outputs change only at a clock edge where upd_en is 1, and enc_dir becomes 1 when the new angle minus the old one, modulo 4096, lies in 1..2047. It becomes 0 when that difference lies in 2048..4095.
- R6: A step from 0xFFF to 0x000 sets enc_dir to 1, and a step from 0x000 to 0xFFF sets enc_dir to 0.
- R7: enc_nm is 1 exactly while the sampled angle equals 0x000. It is therefore one quadrature state wide and always coincides with A=0,B=0.
- R8: When upd_en is 0, a change on angle_in has no effect on any output.
- R9: An update whose new angle equals the sampled angle leaves enc_dir unchanged.
- R10: A single-LSB step changes exactly one of A and B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_en | input | 1 | Position update enable; angle_in is sampled when 1 |
| angle_in | input | 12 | Absolute angle, unsigned, one LSB = 1/4096 turn |
| enc_a | output | 1 | Quadrature channel A |
| enc_b | output | 1 | Quadrature channel B |
| enc_dir | output | 1 | Direction, 1 for increasing angle |
| enc_nm | output | 1 | North marker, high in the zero-angle state |

## Verification
Several properties are checked on every clock cycle by the assertions. The direction response to each forward or backward single step, including across the wrap, is checked continuously. So are the holding of the sampled angle while no update is enabled and the unchanged direction on a zero step. The assertions also check that the marker only appears in the A=0,B=0 state and that a single step toggles exactly one channel. Other behaviour is visible only in the bench's scenarios: the reset values, the lead-lag order of the channels over a run of steps, the 1024-cycle count over a full revolution, and the classification of multi-LSB jumps into forward and backward halves.

// File: rtl/enc_emu_pkg.sv
// Package: shared constants and types for the encoder emulator.
// Assumes: angle width of at least 2 bits (two LSBs form the quadrature state).
package enc_emu_pkg;
    localparam int ENC_ANGLE_W = 12;

    // Quadrature channel pair
    typedef struct packed {
        logic a;
        logic b;
    } quad_t;
endpackage

// File: rtl/enc_angle_tracker.sv
// Module: enc_angle_tracker
// Samples the angle on each update enable and derives the direction of the
// latest non-zero step by modulo subtraction against the previous sample.
// Assumes: synchronous active-low reset; forward half-turn counts as increasing.
module enc_angle_tracker #(
    parameter int ANGLE_W = enc_emu_pkg::ENC_ANGLE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_en,
    input  logic [ANGLE_W-1:0] angle_in,
    output logic [ANGLE_W-1:0] angle_q,
    output logic               dir_q
);
    localparam logic [ANGLE_W-1:0] ZERO_ANG = '0;
    localparam logic [ANGLE_W-1:0] ONE_LSB  = ANGLE_W'(1);

    logic [ANGLE_W-1:0] step_delta;

    // Modulo-one-turn distance from the held angle to the new one
    always_comb step_delta = angle_in - angle_q;

    // Hold the sampled angle and update direction on non-zero steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            angle_q <= ZERO_ANG;
            dir_q   <= 1'b1;
        end else if (upd_en) begin
            angle_q <= angle_in;
            if (step_delta != ZERO_ANG)
                dir_q <= ~step_delta[ANGLE_W-1];
        end
    end

    // R5: forward single step (including wrap to zero) drives direction high
    a_r5_dir_up: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && angle_in == ANGLE_W'(angle_q + ONE_LSB)) |=> dir_q);

    // R5: backward single step drives direction low
    a_r5_dir_down: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && angle_in == ANGLE_W'(angle_q - ONE_LSB)) |=> !dir_q);

    // R9: a zero step keeps the direction
    a_r9_dir_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && angle_in == angle_q) |=> $stable(dir_q));

    // R8: without an update the held angle does not move
    a_r8_hold_angle: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(angle_q));
endmodule

// File: rtl/enc_quad_mapper.sv
// Module: enc_quad_mapper
// Maps the two low angle bits onto Gray-ordered A/B levels so that an
// increasing angle makes A lead B.
// Assumes: angle moves by at most one LSB per update.
module enc_quad_mapper (
    input  logic [1:0]            phase,
    output enc_emu_pkg::quad_t    quad
);
    // Gray mapping: 00->00, 01->10, 10->11, 11->01 (shown as A,B)
    always_comb begin
        quad.a = phase[1] ^ phase[0];
        quad.b = phase[1];
    end
endmodule

// File: rtl/enc_marker_gen.sv
// Module: enc_marker_gen
// Raises the north marker while the sampled angle sits in the zero state.
// Assumes: the marker spans one quadrature state (a quarter A cycle).
module enc_marker_gen #(
    parameter int ANGLE_W = enc_emu_pkg::ENC_ANGLE_W
) (
    input  logic [ANGLE_W-1:0] angle,
    output logic               marker
);
    // Zero-angle detect
    always_comb marker = (angle == '0);
endmodule

// File: rtl/quad_encoder_emu.sv
// Module: quad_encoder_emu
// Top level: incremental encoder emulation from an absolute angle word.
// Assumes: upd_en pulses at the position update rate and the angle moves at
// most one LSB per pulse in normal tracking; larger jumps are classified by
// the shorter way round the circle (forward half counts as increasing).
module quad_encoder_emu #(
    parameter int ANGLE_W = enc_emu_pkg::ENC_ANGLE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_en,
    input  logic [ANGLE_W-1:0] angle_in,
    output logic               enc_a,
    output logic               enc_b,
    output logic               enc_dir,
    output logic               enc_nm
);
    import enc_emu_pkg::*;

    localparam logic [ANGLE_W-1:0] ONE_LSB = ANGLE_W'(1);

    logic [ANGLE_W-1:0] angle_q;
    logic               dir_q;
    quad_t              quad;
    logic               marker;

    enc_angle_tracker #(.ANGLE_W(ANGLE_W)) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .angle_in (angle_in),
        .angle_q  (angle_q),
        .dir_q    (dir_q)
    );

    enc_quad_mapper u_mapper (
        .phase (angle_q[1:0]),
        .quad  (quad)
    );

    enc_marker_gen #(.ANGLE_W(ANGLE_W)) u_marker (
        .angle  (angle_q),
        .marker (marker)
    );

    // Drive the encoder pins from the mapped state
    always_comb begin
        enc_a   = quad.a;
        enc_b   = quad.b;
        enc_dir = dir_q;
        enc_nm  = marker;
    end

    // R7: the marker only appears in the A=0,B=0 state
    a_r7_marker_in_zero_state: assert property (@(posedge clk) disable iff (!rst_n)
        enc_nm |-> (!enc_a && !enc_b));

    // R10: a single-LSB step toggles exactly one channel
    a_r10_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (angle_in == ANGLE_W'(angle_q + ONE_LSB) ||
                    angle_in == ANGLE_W'(angle_q - ONE_LSB)))
        |=> $countones({enc_a, enc_b} ^ $past({enc_a, enc_b})) == 1);

    // R8: no update, no output movement
    a_r8_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable({enc_a, enc_b, enc_dir, enc_nm}));
endmodule

// File: tb/test_quad_encoder_emu.sv
module test_quad_encoder_emu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [11:0] angle_in = '0;
    logic        enc_a, enc_b, enc_dir, enc_nm;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [11:0] m_ang = '0;
    logic        m_dir = 1'b1;

    always #10 clk = ~clk;

    quad_encoder_emu i_quad_encoder_emu (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .angle_in(angle_in),
        .enc_a(enc_a), .enc_b(enc_b), .enc_dir(enc_dir), .enc_nm(enc_nm)
    );

    function automatic logic [3:0] expect_pins(logic [11:0] ang, logic dir);
        return {ang[1] ^ ang[0], ang[1], dir, ang == 12'h000};
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {a,b,dir,nm} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Apply one update (or a held cycle) and check the outputs afterwards
    task automatic apply(bit en, logic [11:0] ang, string req);
        logic [11:0] d;
        @(negedge clk);
        upd_en   = en;
        angle_in = ang;
        @(negedge clk);
        upd_en = 1'b0;
        if (en) begin
            d = ang - m_ang;
            if (d != 12'h000) m_dir = ~d[11];
            m_ang = ang;
        end
        chk(req, {enc_a, enc_b, enc_dir, enc_nm}, expect_pins(m_ang, m_dir));
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int a_rises;
        int nm_pulses;
        logic prev_a, prev_nm;
        void'($urandom(32'd1205));

        // R1: reset state
        angle_in = 12'h5A7;
        @(posedge clk);
        @(negedge clk);
        chk("R1", {enc_a, enc_b, enc_dir, enc_nm}, 4'b0011);
        rst_n = 1'b1;

        // R2 / R3: increasing single steps, A leads B
        apply(1, 12'h001, "R2 R3");
        chk("R3 A leads", {enc_a, enc_b, 2'b00}, 4'b1000);
        apply(1, 12'h002, "R2 R3");
        apply(1, 12'h003, "R2 R3");
        apply(1, 12'h004, "R2 R3");
        // decreasing: B leads A
        apply(1, 12'h003, "R3 R5");
        chk("R3 B leads", {enc_a, enc_b, 2'b00}, 4'b0100);
        apply(1, 12'h002, "R3 R5");

        // R9: zero step keeps direction low
        apply(1, 12'h002, "R9");
        chk("R9 dir kept", {3'b000, enc_dir}, 4'b0000);

        // R8: angle_in ignored without update
        for (int i = 0; i < 6; i++)
            apply(0, 12'($urandom), "R8");

        // R6: wrap both ways
        apply(1, 12'h001, "R6");
        apply(1, 12'h000, "R6 R7");
        apply(1, 12'hFFF, "R6");
        chk("R6 down wrap", {3'b000, enc_dir}, 4'b0000);
        apply(1, 12'h000, "R6 R7");
        chk("R6 up wrap", {3'b000, enc_dir}, 4'b0001);

        // R5: multi-LSB jumps, forward and backward halves
        apply(1, 12'h7FF, "R5 fwd half");
        apply(1, 12'hFFF, "R5 0x800 back");
        apply(1, 12'h100, "R5 jump");

        // R4: full revolution from zero
        apply(1, 12'h000, "R4");
        a_rises = 0; nm_pulses = 0;
        prev_a = enc_a; prev_nm = enc_nm;
        for (int s = 1; s <= 4096; s++) begin
            apply(1, 12'(s), "R4 R2 R7");
            if (enc_a && !prev_a) a_rises++;
            if (enc_nm && !prev_nm) nm_pulses++;
            prev_a = enc_a; prev_nm = enc_nm;
        end
        n_tests++;
        if (a_rises != 1024) begin
            n_fail++;
            $display("FAIL R4: A rises actual=%0d expected=1024", a_rises);
        end
        n_tests++;
        if (nm_pulses != 1) begin
            n_fail++;
            $display("FAIL R4: marker pulses actual=%0d expected=1", nm_pulses);
        end

        // Random walk of -1/0/+1 steps with idle cycles (R5 R8 R9 R10)
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 4)      apply(1, m_ang + 12'd1, "R5 R10 rand up");
            else if (r < 8) apply(1, m_ang - 12'd1, "R5 R10 rand down");
            else if (r == 8) apply(1, m_ang, "R9 rand zero");
            else            apply(0, 12'($urandom), "R8 rand idle");
        end

        // Random jumps of any size (R5)
        for (int i = 0; i < 200; i++)
            apply(1, 12'($urandom), "R5 rand jump");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule